// File: doc/BRIEF.md
# Two-cycle multiply-accumulate unit

This execute-stage unit updates a 64-bit HI/LO accumulator from two 32-bit operands. A plain multiply, signed or unsigned, returns its full 64-bit product with a write strobe in the same cycle the operation is presented.

The accumulate and subtract forms take two cycles. In the first cycle the unit only multiplies. It latches the product internally and raises a stall request, so that the surrounding pipeline presents the same instruction again. In the second cycle the unit adds the held product to the HI/LO value on its input, or subtracts it, and returns the sum with a write strobe. HI is always the upper 32 bits of the 64-bit value.

A single phase bit tracks which cycle is in progress, and a pipeline flush clears it. The HI/LO value arrives on `acc_in`, already resolved by the surrounding pipeline.

Top module: `mac2_unit`

## Requirements
- R1: After reset, with `op_valid` low, `acc_we` and `stall_req` are both low.
- R2: A signed multiply (`op_code` 1) with `op_valid` high drives `acc_out` to the signed 64-bit product of `src_a` and `src_b`, raises `acc_we` and keeps `stall_req` low, all in that same cycle.
- R3: An unsigned multiply (`op_code` 2) behaves as R2, but with the operands taken as unsigned.
- R4: In the first cycle of an accumulate operation (`op_code` 3 to 6, `op_valid` high, no flush), `stall_req` is high and `acc_we` is low.
- R5: In the cycle after R4, `acc_we` is high and `stall_req` is low. The result uses the product latched in the first cycle, even if `src_a` and `src_b` have since changed.
- R6: Signed accumulate (`op_code` 3) gives `acc_out = acc_in + signed(src_a*src_b)` modulo 2^64, with HI as `acc_out[63:32]`.
- R7: Unsigned accumulate (`op_code` 4) gives `acc_in + unsigned(src_a*src_b)` modulo 2^64.
- R8: Signed subtract (`op_code` 5) gives `acc_in - signed(src_a*src_b)`, meaning the accumulator minus the product, modulo 2^64.
- R9: Unsigned subtract (`op_code` 6) gives `acc_in - unsigned(src_a*src_b)` modulo 2^64.
- R10: While `flush` is high there is no write and no stall, and the phase bit clears. The next valid accumulate operation therefore starts again at its first cycle.
- R11: `op_code` 0 or 7 causes no write and no stall, even with `op_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Pipeline flush; cancels the operation in progress |
| op_valid | input | 1 | An operation is present this cycle |
| op_code | input | 3 | Operation select, values 0 to 7 |
| src_a | input | W | First operand |
| src_b | input | W | Second operand |
| acc_in | input | 2W | Current HI/LO value |
| acc_out | output | 2W | New HI/LO value |
| acc_we | output | 1 | Write enable for HI/LO |
| stall_req | output | 1 | Request to hold the instruction one more cycle |

## Verification
The bench builds the unit with the defaults: W = 32, the sign-extension multiplier, and a product register that has a reset. Operand patterns at the extremes of the range, such as all ones and the most negative value, exercise the sign handling and the wrap of the 64-bit sum modulo 2^64. Changing the operands in the second cycle shows that the latched product is the one that gets used. A flush in either cycle shows that the phase bit returns to the first cycle.

// File: rtl/mac2_pkg.sv
package mac2_pkg;

   typedef enum logic [2:0] {
      MAC_NONE  = 3'd0,
      MAC_MUL_S = 3'd1,
      MAC_MUL_U = 3'd2,
      MAC_ADD_S = 3'd3,
      MAC_ADD_U = 3'd4,
      MAC_SUB_S = 3'd5,
      MAC_SUB_U = 3'd6,
      MAC_RSVD  = 3'd7
   } mac_op_e;

   function automatic logic op_is_plain(mac_op_e op);
      return (op == MAC_MUL_S) || (op == MAC_MUL_U);
   endfunction

   function automatic logic op_is_accum(mac_op_e op);
      return (op == MAC_ADD_S) || (op == MAC_ADD_U) ||
             (op == MAC_SUB_S) || (op == MAC_SUB_U);
   endfunction

   function automatic logic op_is_signed(mac_op_e op);
      return (op == MAC_MUL_S) || (op == MAC_ADD_S) || (op == MAC_SUB_S);
   endfunction

   function automatic logic op_is_sub(mac_op_e op);
      return (op == MAC_SUB_S) || (op == MAC_SUB_U);
   endfunction

endpackage

// File: rtl/mac2_mul.sv
module mac2_mul #(
   parameter int W         = 32,
   parameter int MUL_STYLE = 0
) (
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   input  logic           signed_mode,
   output logic [2*W-1:0] prod
);
   localparam int PW = 2 * W;

   generate
      if (MUL_STYLE == 0) begin : g_ext
         logic signed [W:0]    ea;
         logic signed [W:0]    eb;
         logic signed [PW-1:0] full;
         assign ea   = {signed_mode & a[W-1], a};
         assign eb   = {signed_mode & b[W-1], b};
         assign full = ea * eb;
         assign prod = full;
      end else begin : g_corr
         logic [PW-1:0] uprod;
         logic [PW-1:0] fix_a;
         logic [PW-1:0] fix_b;
         assign uprod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
         assign fix_a = (signed_mode && a[W-1]) ? {b, {W{1'b0}}} : '0;
         assign fix_b = (signed_mode && b[W-1]) ? {a, {W{1'b0}}} : '0;
         assign prod  = uprod - fix_a - fix_b;
      end
   endgenerate

endmodule

// File: rtl/mac2_seq.sv
module mac2_seq #(
   parameter int PW         = 64,
   parameter bit HOLD_RESET = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          start,
   input  logic          sub_in,
   input  logic [PW-1:0] prod_in,
   output logic          phase2,
   output logic          sub_q,
   output logic [PW-1:0] prod_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase2 <= 1'b0;
         sub_q  <= 1'b0;
      end else if (flush) begin
         phase2 <= 1'b0;
      end else begin
         phase2 <= start;
         if (start) sub_q <= sub_in;
      end
   end

   generate
      if (HOLD_RESET) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     prod_q <= '0;
            else if (start) prod_q <= prod_in;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (start) prod_q <= prod_in;
         end
      end
   endgenerate

endmodule

// File: rtl/mac2_addsub.sv
module mac2_addsub #(
   parameter int PW = 64
) (
   input  logic [PW-1:0] acc,
   input  logic [PW-1:0] prod,
   input  logic          sub,
   output logic [PW-1:0] sum
);
   logic [PW-1:0] operand;

   assign operand = sub ? ~prod : prod;
   assign sum     = acc + operand + {{(PW-1){1'b0}}, sub};

endmodule

// File: rtl/mac2_unit.sv
module mac2_unit #(
   parameter int W          = 32,
   parameter int MUL_STYLE  = 0,
   parameter bit HOLD_RESET = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           flush,
   input  logic           op_valid,
   input  logic [2:0]     op_code,
   input  logic [W-1:0]   src_a,
   input  logic [W-1:0]   src_b,
   input  logic [2*W-1:0] acc_in,
   output logic [2*W-1:0] acc_out,
   output logic           acc_we,
   output logic           stall_req
);
   import mac2_pkg::*;

   localparam int PW = 2 * W;

   generate
      if (W < 2) begin : g_bad_w
         $error("mac2_unit: W must be at least 2");
      end
      if (MUL_STYLE != 0 && MUL_STYLE != 1) begin : g_bad_style
         $error("mac2_unit: MUL_STYLE must be 0 or 1");
      end
   endgenerate

   mac_op_e       op;
   logic          phase2;
   logic          sub_q;
   logic          first;
   logic [PW-1:0] prod;
   logic [PW-1:0] prod_q;
   logic [PW-1:0] sum;

   assign op    = mac_op_e'(op_code);
   assign first = op_valid && op_is_accum(op) && !phase2 && !flush;

   mac2_mul #(.W(W), .MUL_STYLE(MUL_STYLE)) u_mul (
      .a           (src_a),
      .b           (src_b),
      .signed_mode (op_is_signed(op)),
      .prod        (prod)
   );

   mac2_seq #(.PW(PW), .HOLD_RESET(HOLD_RESET)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .start   (first),
      .sub_in  (op_is_sub(op)),
      .prod_in (prod),
      .phase2  (phase2),
      .sub_q   (sub_q),
      .prod_q  (prod_q)
   );

   mac2_addsub #(.PW(PW)) u_addsub (
      .acc  (acc_in),
      .prod (prod_q),
      .sub  (sub_q),
      .sum  (sum)
   );

   assign stall_req = first;
   assign acc_we    = !flush && (phase2 || (op_valid && op_is_plain(op)));
   assign acc_out   = phase2 ? sum : prod;

endmodule

// File: rtl/mac2_unit_chk.sv
module mac2_unit_chk #(
   parameter int W = 32
) (
   input logic           clk,
   input logic           rst_n,
   input logic           flush,
   input logic           op_valid,
   input logic [2:0]     op_code,
   input logic [W-1:0]   src_a,
   input logic [W-1:0]   src_b,
   input logic [2*W-1:0] acc_in,
   input logic [2*W-1:0] acc_out,
   input logic           acc_we,
   input logic           stall_req
);
   localparam int PW = 2 * W;

   function automatic logic [PW-1:0] ref_prod(logic [W-1:0] a, logic [W-1:0] b, logic s);
      logic [PW-1:0] xa;
      logic [PW-1:0] xb;
      xa = s ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
      xb = s ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
      return xa * xb;
   endfunction

   logic plain_op;
   assign plain_op = (op_code == 3'd1) || (op_code == 3'd2);

   // R1 / R11: no write without a plain multiply or a pending second cycle
   p_idle_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(stall_req) && !(op_valid && plain_op)) |-> !acc_we);

   // R4: a stall is never paired with a write
   p_stall_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      stall_req |-> !acc_we);

   // R5: a stall lasts one cycle and is followed by a write unless flushed
   p_stall_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stall_req |=> !stall_req);
   p_second_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stall_req |=> (acc_we || flush));

   // R2: signed multiply value in a fresh cycle
   p_mul_signed_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 3'd1 && !flush && !$past(stall_req)) |->
      (acc_we && acc_out == ref_prod(src_a, src_b, 1'b1)));

   // R6: signed accumulate uses the first-cycle product
   p_madd_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_req && op_code == 3'd3) |=>
      (flush || acc_out == acc_in + $past(ref_prod(src_a, src_b, 1'b1))));

   // R8: signed subtract is accumulator minus product
   p_msub_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_req && op_code == 3'd5) |=>
      (flush || acc_out == acc_in - $past(ref_prod(src_a, src_b, 1'b1))));

   // R10: no write or stall while flushing
   p_flush_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> (!acc_we && !stall_req));

endmodule

bind mac2_unit mac2_unit_chk #(.W(W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .flush     (flush),
   .op_valid  (op_valid),
   .op_code   (op_code),
   .src_a     (src_a),
   .src_b     (src_b),
   .acc_in    (acc_in),
   .acc_out   (acc_out),
   .acc_we    (acc_we),
   .stall_req (stall_req)
);

// File: tb/mac2_unit_test.sv
`timescale 1ns/1ps
module mac2_unit_test;
   localparam int W = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          flush;
   logic          op_valid;
   logic [2:0]    op_code;
   logic [W-1:0]  src_a;
   logic [W-1:0]  src_b;
   logic [63:0]   acc_in;
   logic [63:0]   acc_out;
   logic          acc_we;
   logic          stall_req;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   mac2_unit uut (
      .clk (clk), .rst_n (rst_n), .flush (flush), .op_valid (op_valid),
      .op_code (op_code), .src_a (src_a), .src_b (src_b), .acc_in (acc_in),
      .acc_out (acc_out), .acc_we (acc_we), .stall_req (stall_req)
   );

   function automatic logic [63:0] eprod(logic [31:0] a, logic [31:0] b, logic s);
      logic [63:0] xa;
      logic [63:0] xb;
      xa = s ? {{32{a[31]}}, a} : {32'b0, a};
      xb = s ? {{32{b[31]}}, b} : {32'b0, b};
      return xa * xb;
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      flush = 1'b0; op_valid = 1'b0; op_code = 3'd0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0; flush = 1'b0; op_valid = 1'b0; op_code = 3'd0;
      src_a = '0; src_b = '0; acc_in = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R1 we", {63'b0, acc_we}, 64'd0);
      chk("R1 stall", {63'b0, stall_req}, 64'd0);
   endtask

   task automatic t_plain(logic [2:0] code, logic [31:0] a, logic [31:0] b, string req);
      @(negedge clk);
      op_valid = 1'b1; op_code = code; src_a = a; src_b = b; acc_in = 64'h1234_5678_9ABC_DEF0;
      #1;
      chk({req, " value"}, acc_out, eprod(a, b, code == 3'd1));
      chk({req, " we"}, {63'b0, acc_we}, 64'd1);
      chk({req, " stall"}, {63'b0, stall_req}, 64'd0);
      idle();
   endtask

   task automatic t_accum(logic [2:0] code, logic [31:0] a, logic [31:0] b,
                          logic [63:0] acc, string req);
      logic [63:0] p;
      logic [63:0] exp;
      p   = eprod(a, b, (code == 3'd3) || (code == 3'd5));
      exp = (code >= 3'd5) ? acc - p : acc + p;
      @(negedge clk);
      op_valid = 1'b1; op_code = code; src_a = a; src_b = b; acc_in = 64'hDEAD_DEAD_DEAD_DEAD;
      #1;
      chk("R4 stall", {63'b0, stall_req}, 64'd1);
      chk("R4 no we", {63'b0, acc_we}, 64'd0);
      @(negedge clk);
      src_a = ~a; src_b = b ^ 32'h5A5A_A5A5; acc_in = acc;
      #1;
      chk({req, " value"}, acc_out, exp);
      chk("R5 we", {63'b0, acc_we}, 64'd1);
      chk("R5 stall", {63'b0, stall_req}, 64'd0);
      idle();
      #1;
      chk("R5 done", {62'b0, acc_we, stall_req}, 64'd0);
   endtask

   task automatic t_flush();
      @(negedge clk);
      op_valid = 1'b1; op_code = 3'd3; src_a = 32'd5; src_b = 32'd6; acc_in = 64'd100;
      flush = 1'b1;
      #1;
      chk("R10 flush first", {62'b0, acc_we, stall_req}, 64'd0);
      @(negedge clk);
      flush = 1'b0;
      #1;
      chk("R10 restart stall", {63'b0, stall_req}, 64'd1);
      @(negedge clk);
      flush = 1'b1;
      #1;
      chk("R10 flush second", {62'b0, acc_we, stall_req}, 64'd0);
      @(negedge clk);
      flush = 1'b0;
      #1;
      chk("R10 after flush stall", {63'b0, stall_req}, 64'd1);
      @(negedge clk); #1;
      chk("R10 completes", acc_out, 64'd130);
      idle();
   endtask

   task automatic t_reserved();
      for (int c = 0; c < 8; c += 7) begin
         @(negedge clk);
         op_valid = 1'b1; op_code = 3'(c); src_a = 32'hFFFF_FFFF; src_b = 32'd3;
         #1;
         chk("R11 no effect", {62'b0, acc_we, stall_req}, 64'd0);
      end
      idle();
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_plain(3'd1, 32'hFFFF_FFFD, 32'd7, "R2");
      t_plain(3'd1, 32'h8000_0000, 32'h8000_0000, "R2");
      t_plain(3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3");
      t_accum(3'd3, 32'hFFFF_FFFE, 32'd9, 64'd1000, "R6");
      t_accum(3'd3, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R6");
      t_accum(3'd4, 32'hFFFF_FFFF, 32'h0000_0010, 64'h0000_0001_0000_0000, "R7");
      t_accum(3'd5, 32'hFFFF_FFF0, 32'd3, 64'd5, "R8");
      t_accum(3'd6, 32'd4, 32'd5, 64'd7, "R9");
      t_accum(3'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 64'd0, "R9");
      t_flush();
      t_reserved();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule